// File: doc/BRIEF.md
# Key Event Queue With Overflow Policy

This block stores key and general-purpose-input events in arrival order until a host reads them out. Each event arrives on a push port as a 7-bit identifier plus a pressed/released flag. The block packs the two into one byte and appends that byte to a ten-slot ring. The host drains the ring through a small read window of ten consecutive addresses. A read at any address in that window returns the oldest stored byte and removes it, so software can either poll one address or sweep the whole window.

A registered occupancy count and an empty flag show how many events are waiting. When a push meets a full ring, a mode input picks the policy. The block either discards the incoming event, or keeps it and drops the oldest stored one. In both cases a one-cycle overflow pulse reports the collision. Read data is registered and appears on the cycle after the read.

Top module: `key_event_queue`

## Requirements
- R1: The queue holds up to DEPTH events (default 10) and returns them oldest first.
- R2: A stored byte carries the identifier in bits 6:0 and the event type in bit 7, where 1 means pressed and 0 means released.
- R3: Identifiers from both ranges in use, key matrix 1 to 80 and input pins 97 to 114, are returned exactly as pushed.
- R4: `count` is registered, ranges from 0 to DEPTH, goes up by one per accepted push and down by one per pop, and `empty` is high exactly when `count` is 0.
- R5: A read with `rd_addr` in BASE_ADDR to BASE_ADDR+DEPTH-1 (default 0x04 to 0x0D) pops the oldest entry onto `rd_data` in the next cycle. In any cycle not following a pop, `rd_data` is 0x00.
- R6: With `ovf_mode` = 1, a push into a full queue without a same-cycle pop discards the oldest entry, keeps the new one, and leaves `count` at DEPTH.
- R7: With `ovf_mode` = 0, a push into a full queue without a same-cycle pop is lost, and the stored entries are unchanged.
- R8: `overflow` is high for exactly one cycle after each push that meets a full queue with no same-cycle pop, in either mode, and is low otherwise.
- R9: A read in the window while the queue is empty returns 0x00 and leaves count and contents unchanged.
- R10: A push and a window read in the same cycle on a full queue are handled as pop then push: no overflow, `count` stays DEPTH, and the new event becomes the newest.
- R11: A read outside the window pops nothing and returns 0x00.
- R12: After reset, `count` is 0, `empty` is 1, `rd_data` is 0x00, and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push an event this cycle |
| push_id | input | 7 | Event identifier |
| push_pressed | input | 1 | 1 = pressed, 0 = released |
| ovf_mode | input | 1 | 1 = keep new and drop oldest when full, 0 = drop new |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W (8) | Host read address |
| rd_data | output | 8 | Popped event, valid the cycle after a read |
| count | output | $clog2(DEPTH+1) (4) | Stored event count |
| empty | output | 1 | Queue is empty |
| overflow | output | 1 | One-cycle pulse after a push meets a full queue |

## Verification
The bench builds the block with its defaults: DEPTH of 10, an 8-bit address and a window base of 0x04. With only ten slots, random traffic fills the ring within a few dozen cycles, so the full-queue policies and the same-cycle pop-and-push case come up again and again. The random addresses range over the window and the two addresses on either side of it, 0x02, 0x03, 0x0E and 0x0F, which exercises both edges of the address decode.

// File: rtl/kevq_pkg.sv
package kevq_pkg;
    localparam int unsigned KEVQ_ID_W  = 7;
    localparam int unsigned KEVQ_EVT_W = KEVQ_ID_W + 1;

    typedef logic [KEVQ_EVT_W-1:0] evt_t;

    function automatic evt_t kevq_pack(input logic pressed, input logic [KEVQ_ID_W-1:0] id);
        return {pressed, id};
    endfunction
endpackage

// File: rtl/kevq_addr_match.sv
module kevq_addr_match #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 4,
    parameter int unsigned SPAN      = 10
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hit
);
    localparam int unsigned EW = ADDR_W + 1;
    localparam logic [EW-1:0] LO = EW'(BASE_ADDR);
    localparam logic [EW-1:0] HI = EW'(BASE_ADDR + SPAN);

    logic [EW-1:0] addr_ext;

    always_comb begin
        addr_ext = {1'b0, rd_addr};
        hit      = (addr_ext >= LO) && (addr_ext < HI);
    end
endmodule

// File: rtl/kevq_mem.sv
module kevq_mem
    import kevq_pkg::*;
#(
    parameter int unsigned DEPTH = 10,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  evt_t             wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output evt_t             rd_data
);
    evt_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/kevq_ctrl.sv
module kevq_ctrl
    import kevq_pkg::*;
#(
    parameter int unsigned DEPTH = 10,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             ovf_mode,
    input  logic             rd_hit,
    input  evt_t             head_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output evt_t             rd_data
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic             ovf;
        evt_t             rdata;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     pop, room, accept;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.ovf  = 1'b0;
        st_d.rdata = '0;
        wr_en     = 1'b0;
        accept    = 1'b0;

        // Pop is evaluated first so a full queue can accept a push in the same cycle.
        pop  = rd_hit && (st_q.count != '0);
        room = (st_q.count != FULL_CNT) || pop;

        if (pop) begin
            st_d.rdata = head_data;
            st_d.head  = wrap_inc(st_q.head);
        end

        if (push_valid) begin
            if (room) begin
                wr_en     = 1'b1;
                accept    = 1'b1;
                st_d.tail = wrap_inc(st_q.tail);
            end else begin
                st_d.ovf = 1'b1;
                if (ovf_mode) begin
                    // Full ring: tail equals head, so the oldest slot is overwritten.
                    wr_en     = 1'b1;
                    st_d.tail = wrap_inc(st_q.tail);
                    st_d.head = wrap_inc(st_q.head);
                end
            end
        end

        unique case ({accept, pop})
            2'b10:   st_d.count = st_q.count + CNT_W'(1);
            2'b01:   st_d.count = st_q.count - CNT_W'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_idx   = st_q.tail;
    assign head_idx = st_q.head;
    assign count    = st_q.count;
    assign overflow = st_q.ovf;
    assign rd_data  = st_q.rdata;
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kevq_pkg::*;
#(
    parameter int unsigned DEPTH     = 10,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [KEVQ_ID_W-1:0]       push_id,
    input  logic                       push_pressed,
    input  logic                       ovf_mode,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [KEVQ_EVT_W-1:0]      rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       overflow
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             addr_hit, rd_hit, wr_en;
    logic [IDX_W-1:0] wr_idx, head_idx;
    evt_t             head_data, push_evt;

    kevq_addr_match #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .SPAN     (DEPTH)
    ) u_match (
        .rd_addr(rd_addr),
        .hit    (addr_hit)
    );

    assign rd_hit   = rd_en && addr_hit;
    assign push_evt = kevq_pack(push_pressed, push_id);

    kevq_mem #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(push_evt),
        .rd_idx (head_idx),
        .rd_data(head_data)
    );

    kevq_ctrl #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .ovf_mode  (ovf_mode),
        .rd_hit    (rd_hit),
        .head_data (head_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .head_idx  (head_idx),
        .count     (count),
        .overflow  (overflow),
        .rd_data   (rd_data)
    );

    assign empty = (count == '0);
endmodule

// File: rtl/kevq_check.sv
module kevq_check #(
    parameter int unsigned DEPTH     = 10,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 4,
    parameter int unsigned CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              ovf_mode,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [CNT_W-1:0]  count,
    input logic              empty,
    input logic              overflow
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic in_win, win_rd, full;
    assign in_win = (int'(rd_addr) >= int'(BASE_ADDR)) && (int'(rd_addr) < int'(BASE_ADDR + DEPTH));
    assign win_rd = rd_en && in_win;
    assign full   = (count == FULL_CNT);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_pop_decrements_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && !empty && !push_valid) |=> (count == $past(count) - CNT_W'(1)));

    assert_keep_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !win_rd && ovf_mode) |=> full);

    assert_drop_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !win_rd && !ovf_mode) |=> full);

    assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !win_rd) |=> overflow);

    assert_no_ovf_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !push_valid |=> !overflow);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && empty && !push_valid) |=> (rd_data == 8'h00 && empty));

    assert_pop_then_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && win_rd && full) |=> (!overflow && full));

    assert_outside_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_win && !push_valid) |=> ($stable(count) && rd_data == 8'h00));
endmodule

bind key_event_queue kevq_check #(
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .CNT_W    ($clog2(DEPTH + 1))
) u_kevq_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .ovf_mode  (ovf_mode),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .count     (count),
    .empty     (empty),
    .overflow  (overflow)
);

// File: tb/key_event_queue_bench.sv
module key_event_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;
    localparam int BASE       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [6:0] push_id = '0;
    logic       push_pressed = 1'b0;
    logic       ovf_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] count;
    logic       empty;
    logic       overflow;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R12";
    logic [7:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    key_event_queue u_key_event_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_id(push_id),
        .push_pressed(push_pressed), .ovf_mode(ovf_mode), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .empty(empty),
        .overflow(overflow)
    );

    function automatic logic in_window(input logic [7:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + DEPTH);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual 0x%0h expected 0x%0h", req, cur_req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, check at the following negedge.
    task automatic step(input logic pv, input logic [6:0] id, input logic pr,
                        input logic md, input logic re, input logic [7:0] ad);
        logic [7:0] exp_rd;
        logic       exp_ovf;
        exp_rd  = 8'h00;
        exp_ovf = 1'b0;
        push_valid = pv; push_id = id; push_pressed = pr;
        ovf_mode = md; rd_en = re; rd_addr = ad;
        if (re && in_window(ad) && mq.size() > 0) exp_rd = mq.pop_front();
        if (pv) begin
            if (mq.size() < DEPTH) mq.push_back({pr, id});
            else begin
                exp_ovf = 1'b1;
                if (md) begin
                    void'(mq.pop_front());
                    mq.push_back({pr, id});
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; rd_en = 1'b0;
        check("R5 rd_data", int'(rd_data), int'(exp_rd));
        check("R4 count", int'(count), mq.size());
        check("R4 empty", int'(empty), int'(mq.size() == 0));
        check("R8 overflow", int'(overflow), int'(exp_ovf));
    endtask

    task automatic push_ev(input logic [6:0] id, input logic pr, input logic md);
        step(1'b1, id, pr, md, 1'b0, 8'h00);
    endtask

    task automatic read_at(input logic [7:0] ad);
        step(1'b0, 7'd0, 1'b0, 1'b0, 1'b1, ad);
    endtask

    task automatic drain();
        while (mq.size() > 0) read_at(8'(BASE));
    endtask

    task automatic fill_mixed();
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 2 == 0) push_ev(7'(1 + i * 8), 1'b1, 1'b0);
            else            push_ev(7'(97 + i * 2), 1'b0, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        cur_req = "R12";
        check("R12 count", int'(count), 0);
        check("R12 empty", int'(empty), 1);
        check("R12 rd_data", int'(rd_data), 0);
        check("R12 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R2";
        push_ev(7'd5, 1'b1, 1'b0);
        push_ev(7'd80, 1'b0, 1'b0);
        read_at(8'h04);
        read_at(8'h04);

        cur_req = "R1 R3";
        push_ev(7'd1, 1'b1, 1'b0);
        push_ev(7'd80, 1'b1, 1'b0);
        push_ev(7'd97, 1'b0, 1'b0);
        push_ev(7'd114, 1'b1, 1'b0);
        fill_mixed();
        for (int a = 0; a < DEPTH; a++) read_at(8'(BASE + a));
        drain();

        cur_req = "R7";
        fill_mixed();
        push_ev(7'd42, 1'b1, 1'b0);
        push_ev(7'd43, 1'b1, 1'b0);
        drain();

        cur_req = "R6";
        fill_mixed();
        push_ev(7'd60, 1'b1, 1'b1);
        push_ev(7'd100, 1'b0, 1'b1);
        drain();

        cur_req = "R9";
        read_at(8'h04);
        read_at(8'h0D);

        cur_req = "R10";
        fill_mixed();
        step(1'b1, 7'd77, 1'b1, 1'b0, 1'b1, 8'h0D);
        step(1'b1, 7'd78, 1'b0, 1'b1, 1'b1, 8'h04);

        cur_req = "R11";
        read_at(8'h03);
        read_at(8'h0E);
        read_at(8'hFF);
        drain();

        cur_req = "random";
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] ad;
            logic [6:0] id;
            ad = 8'(2 + ($urandom % 14));
            id = ($urandom % 2) ? 7'(1 + $urandom % 80) : 7'(97 + $urandom % 18);
            step(($urandom % 8) < 5, id, 1'(($urandom)), 1'(($urandom)),
                 ($urandom % 8) < 4, ad);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule